// File: doc/BRIEF.md
# Debug-Port Memory Access Bridge

This block sits behind a debug test access port and turns scanned address and data registers into accesses on an internal request/acknowledge bus. The port state machine is outside the block. It delivers each completed instruction scan as a one-cycle `ir_scan` pulse with a 2-bit code. It delivers each completed data-register scan as a one-cycle `dr_scan` pulse with the shifted-in word. The block returns the capture word of that scan on `scan_out`, with `scan_done` pulsing one cycle later. The three low bits of every capture word are status: busy, error and protected.

The host selects an instruction, scans an address word, and then scans data words. Each data word either supplies write data or collects the read data of the previous access. In block mode the address advances by the access size after each accepted data word. In stream mode the address stays fixed, so one address can be pumped repeatedly. A cancel instruction lets the host abort a stuck access while it polls. Three lock inputs decide whether memory access is permitted at all. While access is locked, address and data scans are dropped but the selected mode is kept.

Top module: `jbr_top`

## Requirements
- R1: Every scan returns a capture word with bit 0 = busy, bit 1 = error, bit 2 = protected, and the payload in bits [DW+2:3]. The status is the state just before the scan took effect. `scan_out` changes, and `scan_done` pulses, on the clock edge that samples the scan pulse.
- R2: After reset `scan_out` is zero, no bus request is pending, and the error flag is already set before any access has run.
- R3: The error flag takes the value of `bus_err` when an access is acknowledged, and is cleared on the edge that starts a new access.
- R4: Protected is set whenever the memory controller is held in reset (`lock_hold`), has not loaded its security setting (`lock_ready` low), or has security active (`lock_secure`). It follows these inputs one cycle late and is reported in both instruction and data scans.
- R5: While protected, address and data scans start no access, return a zero payload and change neither the address nor the mode. The data instruction stays selected, so the next data scan after unlock acts normally.
- R6: While busy, any address or data scan has no effect and returns a zero payload.
- R7: With instruction code 0 (address), a data-register scan loads address [AW-1:0], size [AW+1:AW] (bytes = 2^size), block flag [AW+2] and read flag [AW+3]. If the read flag is set, a read starts at once even when the error flag is set.
- R8: With code 1 (data) in write mode, a scan starts a write of the scanned word at the current address, even if the previous write failed. The address then advances by 2^size in block mode and stays put in stream mode.
- R9: With code 1 in read mode, a scan returns the data of the last completed read. It then starts the next read at the advanced address (block mode) or at the same address (stream mode).
- R10: With code 2 (cancel), a scan while busy drops the request on that edge and sets the error flag, and cancel takes priority over an acknowledge on the same edge. A cancel scan while idle has no effect.
- R11: An instruction scan always selects the new code, even while busy or protected, and starts nothing. Code 3 makes data scans return status only.
- R12: Once raised, `bus_req` stays high with stable address, size, direction and write data until it is acknowledged or cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_scan | input | 1 | One-cycle pulse: instruction scan completed |
| ir_code | input | 2 | Instruction code: 0 address, 1 data, 2 cancel, 3 idle |
| dr_scan | input | 1 | One-cycle pulse: data-register scan completed |
| dr_in | input | DW | Word shifted in by the data-register scan |
| scan_out | output | DW+3 | Capture word: status in bits [2:0], payload above |
| scan_done | output | 1 | Pulses one cycle after a scan pulse |
| lock_hold | input | 1 | Memory controller held in reset |
| lock_ready | input | 1 | Security setting has been loaded |
| lock_secure | input | 1 | Security setting is active |
| bus_req | output | 1 | Bus access request, held until acknowledge |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_size | output | 2 | Access size, bytes = 2^size |
| bus_addr | output | AW | Access byte address |
| bus_wdata | output | DW | Write data |
| bus_ack | input | 1 | Access complete |
| bus_err | input | 1 | Access failed, valid with `bus_ack` |
| bus_rdata | input | DW | Read data, valid with `bus_ack` |

## Verification
A wrong address register or block/stream choice shows as a wrong `bus_addr` on the very next access request, one edge after the data scan. A stale or misplaced error or busy bit appears in the low bits of the next capture word, which is compared on the edge after that scan. A lost protected gate is visible as a `bus_req` rising during a locked scan. A dropped read data latch turns up as a wrong payload on the following read-mode data scan. A reference model that runs alongside the design compares every one of these ports on each clock, so a divergence is reported in the cycle where it first appears.

// File: rtl/jbr_pkg.sv
package jbr_pkg;
  typedef enum logic [1:0] {
    IR_ADDR   = 2'd0,
    IR_DATA   = 2'd1,
    IR_CANCEL = 2'd2,
    IR_IDLE   = 2'd3
  } ir_e;

  localparam int ST_W = 3;
endpackage

// File: rtl/jbr_lock.sv
module jbr_lock (
  input  logic clk,
  input  logic rst,
  input  logic lock_hold,
  input  logic lock_ready,
  input  logic lock_secure,
  output logic prot
);
  always_ff @(posedge clk) begin
    if (rst) prot <= 1'b1;
    else     prot <= lock_hold | ~lock_ready | lock_secure;
  end

  p_lock_r4: assert property (@(posedge clk) disable iff (rst)
    (lock_secure || lock_hold) |=> prot);
endmodule

// File: rtl/jbr_bus_master.sv
module jbr_bus_master #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          st_we,
  input  logic [AW-1:0] st_addr,
  input  logic [1:0]    st_size,
  input  logic [DW-1:0] st_wdata,
  input  logic          cancel,
  input  logic          bus_ack,
  input  logic          bus_err,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [DW-1:0] bus_wdata,
  output logic          err_flag,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_size  <= '0;
      bus_wdata <= '0;
      err_flag  <= 1'b1;
      rd_data   <= '0;
    end else if (cancel && bus_req) begin
      bus_req  <= 1'b0;
      err_flag <= 1'b1;
    end else if (bus_req && bus_ack) begin
      bus_req  <= 1'b0;
      err_flag <= bus_err;
      rd_data  <= bus_rdata;
    end else if (start) begin
      bus_req   <= 1'b1;
      bus_we    <= st_we;
      bus_addr  <= st_addr;
      bus_size  <= st_size;
      bus_wdata <= st_wdata;
      err_flag  <= 1'b0;
    end
  end

  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack && !cancel) |=>
      (bus_req && $stable(bus_addr) && $stable(bus_we) &&
       $stable(bus_size) && $stable(bus_wdata)));

  p_cancel_r10: assert property (@(posedge clk) disable iff (rst)
    (cancel && bus_req) |=> (!bus_req && err_flag));

  p_ack_err_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_ack && !cancel) |=> (err_flag == $past(bus_err)));

  p_start_clr_r3: assert property (@(posedge clk) disable iff (rst)
    (start && !bus_req) |=> (bus_req && !err_flag));
endmodule

// File: rtl/jbr_scan_ctl.sv
module jbr_scan_ctl
  import jbr_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ir_scan,
  input  logic [1:0]         ir_code,
  input  logic               dr_scan,
  input  logic [DW-1:0]      dr_in,
  input  logic               busy,
  input  logic               prot,
  input  logic               err_flag,
  input  logic [DW-1:0]      rd_data,
  output logic               start,
  output logic               st_we,
  output logic [AW-1:0]      st_addr,
  output logic [1:0]         st_size,
  output logic [DW-1:0]      st_wdata,
  output logic               cancel,
  output logic [DW+ST_W-1:0] scan_out,
  output logic               scan_done
);
  localparam int RD_BIT  = AW + 3;
  localparam int BLK_BIT = AW + 2;
  localparam int SZ_LO   = AW;

  ir_e           ir_q;
  logic [AW-1:0] addr_q;
  logic [1:0]    size_q;
  logic          blk_q;
  logic          rd_q;

  logic          dr_act;
  logic [AW-1:0] step;
  logic [AW-1:0] adv;
  logic [DW-1:0] payload;
  logic [ST_W-1:0] status;

  always_comb begin
    step   = AW'(1) << size_q;
    adv    = blk_q ? (addr_q + step) : addr_q;
    dr_act = dr_scan && !ir_scan && !busy && !prot;
    status = {prot, err_flag, busy};

    start    = 1'b0;
    st_we    = 1'b0;
    st_addr  = addr_q;
    st_size  = size_q;
    st_wdata = dr_in;
    if (ir_q == IR_ADDR) begin
      start   = dr_act && dr_in[RD_BIT];
      st_addr = dr_in[AW-1:0];
      st_size = dr_in[SZ_LO+1:SZ_LO];
    end else if (ir_q == IR_DATA) begin
      start   = dr_act;
      st_we   = !rd_q;
      st_addr = rd_q ? adv : addr_q;
    end

    cancel = dr_scan && !ir_scan && (ir_q == IR_CANCEL);

    payload = '0;
    if (dr_scan && !ir_scan && (ir_q == IR_DATA) && rd_q && !busy && !prot)
      payload = rd_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q      <= IR_ADDR;
      addr_q    <= '0;
      size_q    <= '0;
      blk_q     <= 1'b0;
      rd_q      <= 1'b0;
      scan_out  <= '0;
      scan_done <= 1'b0;
    end else begin
      scan_done <= ir_scan | dr_scan;
      if (ir_scan || dr_scan) scan_out <= {payload, status};
      if (ir_scan) begin
        ir_q <= ir_e'(ir_code);
      end else if (dr_act) begin
        if (ir_q == IR_ADDR) begin
          addr_q <= dr_in[AW-1:0];
          size_q <= dr_in[SZ_LO+1:SZ_LO];
          blk_q  <= dr_in[BLK_BIT];
          rd_q   <= dr_in[RD_BIT];
        end else if (ir_q == IR_DATA) begin
          addr_q <= adv;
        end
      end
    end
  end

  p_done_r1: assert property (@(posedge clk) disable iff (rst)
    (ir_scan || dr_scan) |=> scan_done);

  p_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (dr_scan && busy) |-> !start);

  p_prot_r5: assert property (@(posedge clk) disable iff (rst)
    prot |-> !start);

  p_ir_r11: assert property (@(posedge clk) disable iff (rst)
    ir_scan |-> (!start && !cancel));
endmodule

// File: rtl/jbr_top.sv
module jbr_top #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ir_scan,
  input  logic [1:0]    ir_code,
  input  logic          dr_scan,
  input  logic [DW-1:0] dr_in,
  output logic [DW+2:0] scan_out,
  output logic          scan_done,
  input  logic          lock_hold,
  input  logic          lock_ready,
  input  logic          lock_secure,
  output logic          bus_req,
  output logic          bus_we,
  output logic [1:0]    bus_size,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic          bus_err,
  input  logic [DW-1:0] bus_rdata
);
  logic          prot;
  logic          err_flag;
  logic [DW-1:0] rd_data;
  logic          start;
  logic          st_we;
  logic [AW-1:0] st_addr;
  logic [1:0]    st_size;
  logic [DW-1:0] st_wdata;
  logic          cancel;

  jbr_lock u_lock (
    .clk(clk), .rst(rst),
    .lock_hold(lock_hold), .lock_ready(lock_ready), .lock_secure(lock_secure),
    .prot(prot)
  );

  jbr_scan_ctl #(.AW(AW), .DW(DW)) u_ctl (
    .clk(clk), .rst(rst),
    .ir_scan(ir_scan), .ir_code(ir_code),
    .dr_scan(dr_scan), .dr_in(dr_in),
    .busy(bus_req), .prot(prot), .err_flag(err_flag), .rd_data(rd_data),
    .start(start), .st_we(st_we), .st_addr(st_addr), .st_size(st_size),
    .st_wdata(st_wdata), .cancel(cancel),
    .scan_out(scan_out), .scan_done(scan_done)
  );

  jbr_bus_master #(.AW(AW), .DW(DW)) u_bus (
    .clk(clk), .rst(rst),
    .start(start), .st_we(st_we), .st_addr(st_addr), .st_size(st_size),
    .st_wdata(st_wdata), .cancel(cancel),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata),
    .err_flag(err_flag), .rd_data(rd_data)
  );
endmodule

// File: tb/jbr_top_bench.sv
module jbr_top_bench;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ir_scan = 1'b0;
  logic [1:0]    ir_code = 2'd0;
  logic          dr_scan = 1'b0;
  logic [DW-1:0] dr_in = '0;
  logic [DW+2:0] scan_out;
  logic          scan_done;
  logic          lock_hold = 1'b0;
  logic          lock_ready = 1'b1;
  logic          lock_secure = 1'b0;
  logic          bus_req, bus_we;
  logic [1:0]    bus_size;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_ack = 1'b0;
  logic          bus_err = 1'b0;
  logic [DW-1:0] bus_rdata = '0;

  jbr_top #(.AW(AW), .DW(DW)) u_jbr_top (
    .clk(clk), .rst(rst), .ir_scan(ir_scan), .ir_code(ir_code),
    .dr_scan(dr_scan), .dr_in(dr_in), .scan_out(scan_out), .scan_done(scan_done),
    .lock_hold(lock_hold), .lock_ready(lock_ready), .lock_secure(lock_secure),
    .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit running = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- bus slave ----------------
  logic [DW-1:0] mem [logic [AW-1:0]];
  int slave_lat = 2;
  int wcnt = 0;
  always @(negedge clk) begin
    if (bus_req && !bus_ack) begin
      if (wcnt >= slave_lat) begin
        bus_ack = 1'b1;
        bus_err = (bus_addr[AW-1:AW-4] >= 4'hE);
        if (bus_err) bus_rdata = '0;
        else if (bus_we) begin mem[bus_addr] = bus_wdata; bus_rdata = '0; end
        else bus_rdata = mem.exists(bus_addr) ? mem[bus_addr] : '0;
        wcnt = 0;
      end else wcnt++;
    end else begin
      bus_ack = 1'b0;
      bus_err = 1'b0;
      if (!bus_req) wcnt = 0;
    end
  end

  // ---------------- reference model ----------------
  logic          m_req, m_we, m_err, m_prot, m_done, m_rd, m_blk;
  logic [1:0]    m_size, m_ssize, m_ir;
  logic [AW-1:0] m_addr, m_baddr;
  logic [DW-1:0] m_wdata, m_rdata;
  logic [DW+2:0] m_out;

  always @(posedge clk) begin
    logic busy, prot, act, cancelled, go, gwe;
    logic [AW-1:0] ga, nxt;
    logic [1:0] gs;
    logic [DW-1:0] pay;
    if (rst) begin
      m_req = 0; m_we = 0; m_err = 1; m_prot = 1; m_done = 0; m_rd = 0; m_blk = 0;
      m_size = 0; m_ssize = 0; m_ir = 0; m_addr = 0; m_baddr = 0;
      m_wdata = 0; m_rdata = 0; m_out = 0;
    end else begin
      busy = m_req; prot = m_prot; cancelled = 0; go = 0; gwe = 0;
      ga = 0; gs = 0; pay = 0;
      if (ir_scan) begin
        m_out = {{DW{1'b0}}, prot, m_err, busy};
        m_ir = ir_code;
      end else if (dr_scan) begin
        act = !busy && !prot;
        if (m_ir == 2'd1 && m_rd && act) pay = m_rdata;
        m_out = {pay, prot, m_err, busy};
        if (m_ir == 2'd2) begin
          if (m_req) begin m_req = 0; m_err = 1; cancelled = 1; end
        end else if (act && m_ir == 2'd0) begin
          m_addr = dr_in[AW-1:0]; m_ssize = dr_in[AW+1:AW];
          m_blk = dr_in[AW+2]; m_rd = dr_in[AW+3];
          if (m_rd) begin go = 1; ga = m_addr; gs = m_ssize; end
        end else if (act && m_ir == 2'd1) begin
          nxt = m_blk ? m_addr + (AW'(1) << m_ssize) : m_addr;
          go = 1; gs = m_ssize; gwe = !m_rd;
          ga = m_rd ? nxt : m_addr;
          m_addr = nxt;
        end
      end
      if (!cancelled && busy && bus_ack) begin
        m_req = 0; m_err = bus_err; m_rdata = bus_rdata;
      end
      if (go) begin
        m_req = 1; m_we = gwe; m_baddr = ga; m_size = gs; m_wdata = dr_in; m_err = 0;
      end
      m_done = ir_scan | dr_scan;
      m_prot = lock_hold | ~lock_ready | lock_secure;
    end
  end

  always @(negedge clk) begin
    if (running && !rst) begin
      chk(scan_out == m_out, "R1 scan_out", 64'(scan_out), 64'(m_out));
      chk(scan_done == m_done, "R1 scan_done", 64'(scan_done), 64'(m_done));
      chk(bus_req == m_req, "R12 bus_req", 64'(bus_req), 64'(m_req));
      if (m_req) begin
        chk(bus_addr == m_baddr, "R8 bus_addr", 64'(bus_addr), 64'(m_baddr));
        chk(bus_we == m_we, "R7 bus_we", 64'(bus_we), 64'(m_we));
        chk(bus_size == m_size, "R7 bus_size", 64'(bus_size), 64'(m_size));
        if (m_we) chk(bus_wdata == m_wdata, "R8 bus_wdata", 64'(bus_wdata), 64'(m_wdata));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_ir(input logic [1:0] c, output logic [DW+2:0] r);
    @(negedge clk); ir_scan = 1'b1; ir_code = c;
    @(negedge clk); ir_scan = 1'b0; r = scan_out;
  endtask

  task automatic do_dr(input logic [DW-1:0] d, output logic [DW+2:0] r);
    @(negedge clk); dr_scan = 1'b1; dr_in = d;
    @(negedge clk); dr_scan = 1'b0; r = scan_out;
  endtask

  task automatic wait_idle();
    while (bus_req) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] aw(input bit rd, input bit blk, input logic [1:0] sz, input logic [AW-1:0] a);
    return {{(DW-AW-4){1'b0}}, rd, blk, sz, a};
  endfunction

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    compared++; mismatched++;
    $display("FAIL watchdog: actual running expected done");
    report();
  end

  initial begin
    logic [DW+2:0] r;
    repeat (4) @(negedge clk);
    rst = 1'b0; running = 1;
    @(negedge clk);
    chk(scan_out == '0, "R2 reset scan_out", 64'(scan_out), 0);
    chk(bus_req == 1'b0, "R2 reset bus_req", 64'(bus_req), 0);
    do_ir(2'd0, r);
    chk(r[2:0] == 3'b010, "R2 error set at power-up", 64'(r[2:0]), 64'h2);

    // block write
    do_dr(aw(0, 1, 2'd2, 16'h0010), r);
    chk(bus_req == 1'b0, "R7 write address starts nothing", 64'(bus_req), 0);
    do_ir(2'd1, r);
    do_dr(32'hA5A5_0001, r);
    chk(bus_req && bus_we && bus_addr == 16'h0010, "R8 first block write", 64'(bus_addr), 64'h10);
    wait_idle();
    do_dr(32'hA5A5_0002, r);
    chk(r[2:0] == 3'b000, "R3 error cleared after good write", 64'(r[2:0]), 0);
    chk(bus_addr == 16'h0014, "R8 block advance", 64'(bus_addr), 64'h14);
    wait_idle();

    // stream write
    do_ir(2'd0, r);
    do_dr(aw(0, 0, 2'd0, 16'h0020), r);
    do_ir(2'd1, r);
    do_dr(32'h11, r);
    wait_idle();
    do_dr(32'h22, r);
    chk(bus_addr == 16'h0020 && bus_size == 2'd0, "R8 stream keeps address", 64'(bus_addr), 64'h20);
    wait_idle();

    // block read
    do_ir(2'd0, r);
    do_dr(aw(1, 1, 2'd2, 16'h0010), r);
    chk(bus_req && !bus_we && bus_addr == 16'h0010, "R7 read starts on address", 64'(bus_addr), 64'h10);
    wait_idle();
    do_ir(2'd1, r);
    do_dr(32'h0, r);
    chk(r[DW+2:3] == 32'hA5A5_0001, "R9 first read data", 64'(r[DW+2:3]), 64'hA5A50001);
    chk(bus_addr == 16'h0014 && !bus_we, "R9 next read advanced", 64'(bus_addr), 64'h14);
    wait_idle();
    do_dr(32'h0, r);
    chk(r[DW+2:3] == 32'hA5A5_0002, "R9 second read data", 64'(r[DW+2:3]), 64'hA5A50002);
    wait_idle();

    // stream read
    do_ir(2'd0, r);
    do_dr(aw(1, 0, 2'd0, 16'h0020), r);
    wait_idle();
    do_ir(2'd1, r);
    do_dr(32'h0, r);
    chk(r[DW+2:3] == 32'h22 && bus_addr == 16'h0020, "R9 stream read", 64'(r[DW+2:3]), 64'h22);
    wait_idle();

    // failing writes
    do_ir(2'd0, r);
    do_dr(aw(0, 1, 2'd2, 16'hE000), r);
    do_ir(2'd1, r);
    do_dr(32'h1, r);
    wait_idle();
    do_dr(32'h2, r);
    chk(r[1] == 1'b1, "R3 error charged to previous write", 64'(r[1]), 1);
    chk(bus_req && bus_addr == 16'hE004, "R8 write accepted after error", 64'(bus_addr), 64'hE004);
    wait_idle();
    do_ir(2'd0, r);
    chk(r[1] == 1'b1, "R4 status in instruction scan", 64'(r[1]), 1);
    do_dr(aw(1, 0, 2'd2, 16'h0010), r);
    chk(r[1] == 1'b1 && bus_req, "R7 address accepted with error set", 64'(bus_req), 1);
    wait_idle();
    do_ir(2'd0, r);
    chk(r[2:0] == 3'b000, "R3 good read clears error", 64'(r[2:0]), 0);

    // busy and cancel
    slave_lat = 20;
    do_dr(aw(1, 1, 2'd2, 16'h0010), r);
    do_dr(aw(0, 0, 2'd0, 16'h0040), r);
    chk(r[0] == 1'b1 && r[DW+2:3] == '0, "R6 busy scan ignored", 64'(r), 64'h1);
    chk(bus_addr == 16'h0010, "R6 request unchanged", 64'(bus_addr), 64'h10);
    do_ir(2'd2, r);
    chk(r[0] == 1'b1, "R11 instruction selected while busy", 64'(r[0]), 1);
    do_dr(32'h0, r);
    chk(bus_req == 1'b0, "R10 cancel drops request", 64'(bus_req), 0);
    do_dr(32'h0, r);
    chk(r[2:0] == 3'b010 && !bus_req, "R10 error after cancel, idle cancel no effect", 64'(r[2:0]), 64'h2);
    slave_lat = 2;

    // protection
    lock_secure = 1'b1;
    repeat (2) @(negedge clk);
    do_ir(2'd0, r);
    chk(r[2] == 1'b1, "R4 protected on secure", 64'(r[2]), 1);
    do_dr(aw(1, 0, 2'd2, 16'h0030), r);
    chk(bus_req == 1'b0, "R5 locked address dropped", 64'(bus_req), 0);
    do_ir(2'd1, r);
    do_dr(32'h0, r);
    chk(r[DW+2:3] == '0 && !bus_req, "R5 locked read data invalid", 64'(r[DW+2:3]), 0);
    lock_secure = 1'b0;
    repeat (2) @(negedge clk);
    do_dr(32'h0, r);
    chk(r[2] == 1'b0 && r[DW+2:3] == 32'hA5A5_0001, "R5 data mode kept after unlock", 64'(r[DW+2:3]), 64'hA5A50001);
    chk(bus_req && bus_addr == 16'h0014, "R5 read resumes at next address", 64'(bus_addr), 64'h14);
    wait_idle();
    lock_ready = 1'b0;
    repeat (2) @(negedge clk);
    do_ir(2'd3, r);
    chk(r[2] == 1'b1, "R4 protected until loaded", 64'(r[2]), 1);
    lock_ready = 1'b1; lock_hold = 1'b1;
    repeat (2) @(negedge clk);
    do_ir(2'd3, r);
    chk(r[2] == 1'b1, "R4 protected while held", 64'(r[2]), 1);
    lock_hold = 1'b0;
    repeat (2) @(negedge clk);
    do_dr(32'hFFFF_FFFF, r);
    chk(r[2] == 1'b0 && !bus_req, "R11 idle code starts nothing", 64'(bus_req), 0);
    repeat (3) @(negedge clk);
    report();
  end
endmodule